// File: doc/BRIEF.md
# Stereo Bitstream Decimator with DC Blocking

This block turns two one-bit delta-sigma streams, one per stereo channel, into signed 18-bit PCM words at one sixty-fourth of the bit rate. Each bit arrives with a strobe on `in_vld`. The block maps each bit to +1 or -1 and passes it through a five-stage cascaded integrator-comb low-pass filter that decimates by 64. This filter suppresses the quantization noise that the modulator has shaped towards high frequencies. The full-width filter result is then rounded down to 18 bits and clamped.

A leaky first-order differentiator follows and removes any DC offset before the word leaves the block. The two channels share one frame counter, so a single `out_vld` pulse marks a new left and right word together. The block runs on the system clock. Strobes may arrive on every clock cycle or with idle cycles between them.

Top module: `sdm_decim`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all filter state. After that edge `out_vld` is low and both outputs read zero.
- R2: Each strobed input bit enters the filter as +1 when it is 1 and as -1 when it is 0. A stream of all zeros therefore drives the outputs negative, and a stream of all ones drives them positive.
- R3: `out_vld` is high for exactly one clock cycle for every 64 strobes. If the strobe that completes a frame is sampled at rising edge k, `out_vld` and the new words are present between edges k+1 and k+2.
- R4: In cycles where `in_vld` is low, the input bits are ignored and no filter state or frame position moves. A stream delivered with idle gaps gives the same words as the same stream delivered without gaps.
- R5: The low-pass decimator is a 5-stage integrator-comb cascade with differential delay 1 and ratio 64. It uses 32-bit two's-complement integrators and comb delays that wrap. For a 1010... stream it settles to zero.
- R6: The decimator result (full scale ±2^30) is brought to 18 bits by adding 2^12 and then shifting arithmetically right by 13. The value is clamped to [-131072, 131071], so a steady all-ones stream gives 131071 at this point.
- R7: The DC blocker computes y = x - x_prev + y_prev - floor(y_prev / 1024) once per output word. Its state is 20 bits and its output is clamped to 18 bits. For a constant input its output decays towards zero.
- R8: The left and right channels are filtered independently: `out_left` depends only on `in_left` and `out_right` depends only on `in_right`. Both words appear under the same `out_vld` pulse.
- R9: After reset, `out_vld` stays low until 64 strobes have been taken. A reset in the middle of a frame restarts frame counting, and the results then match a freshly reset filter.
- R10: Outside reset, `out_left` and `out_right` hold their values in every cycle where `out_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Strobe: the bits on `in_left`/`in_right` are taken this cycle |
| in_left | input | 1 | Left channel modulator bit |
| in_right | input | 1 | Right channel modulator bit |
| out_vld | output | 1 | One-cycle pulse marking new output words |
| out_left | output | 18 | Left PCM word, signed |
| out_right | output | 18 | Right PCM word, signed |

## Verification
The bench drives six bit patterns and compares every word against an arithmetic model of the requirements:
- All ones and all zeros separate the sign mapping, and all ones reaches the clamp at the 18-bit reduction.
- A 1010... stream shows that a tone at half the bit rate is cancelled by the low-pass cascade.
- A 75% density stream on one channel and a 25% density stream on the other show that the channels stay apart and that the DC blocker pulls a constant level back towards zero.
- A pseudo-random density pattern sent with idle gaps and inverted bits in those gaps shows that only strobed bits count.
- A reset in the middle of a frame shows that frame counting restarts and that the pulse timing stays fixed.

// File: rtl/sdm_decim_pkg.sv
package sdm_decim_pkg;

    localparam int unsigned DEF_OUT_W     = 18;
    localparam int unsigned DEF_RATE_LOG2 = 6;
    localparam int unsigned DEF_STAGES    = 5;
    localparam int unsigned DEF_POLE_SH   = 10;
    localparam int unsigned NUM_CH        = 2;

    // CIC gain is 2^(stages*log2(rate)); one sign bit plus one bit so that
    // the exact positive full scale is representable without wrapping.
    function automatic int unsigned acc_width(input int unsigned stages,
                                              input int unsigned rate_log2);
        return stages * rate_log2 + 2;
    endfunction

    // right shift that maps the CIC full scale onto the output word
    function automatic int unsigned scale_shift(input int unsigned stages,
                                                input int unsigned rate_log2,
                                                input int unsigned out_w);
        return stages * rate_log2 - (out_w - 1);
    endfunction

endpackage

// File: rtl/sdm_decim_integ.sv
module sdm_decim_integ #(
    parameter int unsigned ACC_W  = 32,
    parameter int unsigned STAGES = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic             in_bit,
    output logic [ACC_W-1:0] acc_out
);

    typedef logic [ACC_W-1:0] acc_t;

    typedef struct packed {
        acc_t [STAGES-1:0] acc;
    } integ_t;

    integ_t st_d, st_q;

    // chained integrators; each stage adds the freshly updated stage below
    always_comb begin
        acc_t feed;
        st_d = st_q;
        feed = in_bit ? acc_t'(1) : '1;
        if (in_vld) begin
            for (int k = 0; k < STAGES; k++) begin
                st_d.acc[k] = st_q.acc[k] + feed;
                feed        = st_d.acc[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_out = st_q.acc[STAGES-1];

    // R2: a strobed 1 raises the first stage by one, a strobed 0 lowers it
    assert_bit_plus_R2: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_bit) |=> (st_q.acc[0] == $past(st_q.acc[0]) + acc_t'(1)));
    assert_bit_minus_R2: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !in_bit) |=> (st_q.acc[0] == $past(st_q.acc[0]) - acc_t'(1)));

    // R4: idle cycles leave the cascade untouched
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(acc_out));

endmodule

// File: rtl/sdm_decim_comb.sv
module sdm_decim_comb #(
    parameter int unsigned ACC_W  = 32,
    parameter int unsigned STAGES = 5,
    parameter int unsigned OUT_W  = 18,
    parameter int unsigned SHIFT  = 13
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    dec_en,
    input  logic [ACC_W-1:0]        acc_in,
    output logic signed [OUT_W-1:0] sample
);

    typedef logic [ACC_W-1:0]      acc_t;
    typedef logic signed [ACC_W:0] wide_t;

    localparam wide_t RND  = wide_t'(1) <<< (SHIFT - 1);
    localparam wide_t MAXV = (wide_t'(1) <<< (OUT_W - 1)) - wide_t'(1);
    localparam wide_t MINV = -(wide_t'(1) <<< (OUT_W - 1));

    typedef struct packed {
        acc_t [STAGES-1:0] dly;
    } comb_t;

    comb_t st_d, st_q;
    wide_t rnd_w;
    wide_t scl_w;

    // comb cascade evaluated at the decimated instant, then round and clamp
    always_comb begin
        acc_t v;
        st_d = st_q;
        v    = acc_in;
        for (int k = 0; k < STAGES; k++) begin
            if (dec_en) begin
                st_d.dly[k] = v;
            end
            v = v - st_q.dly[k];
        end
        rnd_w = wide_t'({v[ACC_W-1], v}) + RND;
        scl_w = rnd_w >>> SHIFT;
        if (scl_w > MAXV) begin
            sample = MAXV[OUT_W-1:0];
        end else if (scl_w < MINV) begin
            sample = MINV[OUT_W-1:0];
        end else begin
            sample = scl_w[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: comb delays move only at the decimated instant
    assert_comb_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !dec_en |=> $stable(st_q));

    // R5: first comb delay captures the integrator value seen at decimation
    assert_comb_load_R5: assert property (@(posedge clk) disable iff (rst)
        dec_en |=> (st_q.dly[0] == $past(acc_in)));

endmodule

// File: rtl/sdm_decim_dcblk.sv
module sdm_decim_dcblk #(
    parameter int unsigned OUT_W   = 18,
    parameter int unsigned POLE_SH = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    dec_en,
    input  logic signed [OUT_W-1:0] x_in,
    output logic signed [OUT_W-1:0] y_out
);

    localparam int unsigned Y_W = OUT_W + 2;

    typedef logic signed [Y_W-1:0] y_t;

    localparam y_t Y_MAX = (y_t'(1) <<< (OUT_W - 1)) - y_t'(1);
    localparam y_t Y_MIN = -(y_t'(1) <<< (OUT_W - 1));

    typedef struct packed {
        logic signed [OUT_W-1:0] x1;
        y_t                      y;
    } dcb_t;

    dcb_t st_d, st_q;
    y_t   nxt_y;

    // leaky differentiator; pole 1 - 2^-POLE_SH realised as shift-subtract
    always_comb begin
        st_d  = st_q;
        nxt_y = y_t'(x_in) - y_t'(st_q.x1) + st_q.y - (st_q.y >>> POLE_SH);
        if (dec_en) begin
            st_d.x1 = x_in;
            st_d.y  = nxt_y;
        end
    end

    always_comb begin
        if (st_q.y > Y_MAX) begin
            y_out = Y_MAX[OUT_W-1:0];
        end else if (st_q.y < Y_MIN) begin
            y_out = Y_MIN[OUT_W-1:0];
        end else begin
            y_out = st_q.y[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: a settled zero state with an unchanged input stays at zero
    assert_dc_rest_R7: assert property (@(posedge clk) disable iff (rst)
        (dec_en && (x_in == st_q.x1) && (st_q.y == '0)) |=> (st_q.y == '0));

    // R7: previous-input register follows the decimated input
    assert_dc_track_R7: assert property (@(posedge clk) disable iff (rst)
        dec_en |=> (st_q.x1 == $past(x_in)));

endmodule

// File: rtl/sdm_decim.sv
module sdm_decim
    import sdm_decim_pkg::*;
#(
    parameter int unsigned OUT_W     = DEF_OUT_W,
    parameter int unsigned RATE_LOG2 = DEF_RATE_LOG2,
    parameter int unsigned STAGES    = DEF_STAGES,
    parameter int unsigned POLE_SH   = DEF_POLE_SH
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_vld,
    input  logic                    in_left,
    input  logic                    in_right,
    output logic                    out_vld,
    output logic signed [OUT_W-1:0] out_left,
    output logic signed [OUT_W-1:0] out_right
);

    localparam int unsigned ACC_W = acc_width(STAGES, RATE_LOG2);
    localparam int unsigned SHIFT = scale_shift(STAGES, RATE_LOG2, OUT_W);
    localparam logic [RATE_LOG2-1:0] LAST_PHASE = '1;

    typedef struct packed {
        logic [RATE_LOG2-1:0] phase;
        logic                 frame;
        logic                 vld;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // frame position: count strobes, flag the one that completes a frame
    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.frame = 1'b0;
        ctl_d.vld   = ctl_q.frame;
        if (in_vld) begin
            ctl_d.phase = ctl_q.phase + 1'b1;
            if (ctl_q.phase == LAST_PHASE) begin
                ctl_d.frame = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    logic [NUM_CH-1:0]       ch_bit;
    logic signed [OUT_W-1:0] ch_out [NUM_CH];

    assign ch_bit = {in_right, in_left};

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [ACC_W-1:0]        integ_val;
        logic signed [OUT_W-1:0] dec_word;

        sdm_decim_integ #(
            .ACC_W  (ACC_W),
            .STAGES (STAGES)
        ) i_integ (
            .clk     (clk),
            .rst     (rst),
            .in_vld  (in_vld),
            .in_bit  (ch_bit[ch]),
            .acc_out (integ_val)
        );

        sdm_decim_comb #(
            .ACC_W  (ACC_W),
            .STAGES (STAGES),
            .OUT_W  (OUT_W),
            .SHIFT  (SHIFT)
        ) i_comb (
            .clk    (clk),
            .rst    (rst),
            .dec_en (ctl_q.frame),
            .acc_in (integ_val),
            .sample (dec_word)
        );

        sdm_decim_dcblk #(
            .OUT_W   (OUT_W),
            .POLE_SH (POLE_SH)
        ) i_dcblk (
            .clk    (clk),
            .rst    (rst),
            .dec_en (ctl_q.frame),
            .x_in   (dec_word),
            .y_out  (ch_out[ch])
        );
    end

    assign out_vld   = ctl_q.vld;
    assign out_left  = ch_out[0];
    assign out_right = ch_out[1];

    // R1: reset edge leaves a quiet, zeroed output
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_vld && (out_left == '0) && (out_right == '0)));

    // R3: a pulse never lasts longer than one cycle
    assert_vld_single_R3: assert property (@(posedge clk) disable iff (rst)
        out_vld |=> !out_vld);

    // R3: a pulse always traces back to a strobe two cycles earlier
    assert_vld_after_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> $past(in_vld, 2));

    // R3: frame position wraps after the last strobe of a frame
    assert_phase_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (in_vld && (ctl_q.phase == LAST_PHASE)) |=> (ctl_q.phase == '0));

    // R10: output words move only together with the valid pulse
    assert_out_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (!$stable(out_left) || !$stable(out_right))) |-> out_vld);

endmodule

// File: tb/test_sdm_decim.sv
`timescale 1ns/1ps
module test_sdm_decim;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_vld = 1'b0;
    logic               in_left = 1'b0;
    logic               in_right = 1'b0;
    logic               out_vld;
    logic signed [17:0] out_left;
    logic signed [17:0] out_right;

    always #2.5 clk = ~clk;

    sdm_decim i_sdm_decim (
        .clk       (clk),
        .rst       (rst),
        .in_vld    (in_vld),
        .in_left   (in_left),
        .in_right  (in_right),
        .out_vld   (out_vld),
        .out_left  (out_left),
        .out_right (out_right)
    );

    int     n_checks = 0;
    int     n_errors = 0;
    bit     finished = 1'b0;
    string  cur_req  = "R1";

    // ---------------- reference model built from the requirements ----------
    int     m_int [2][5];
    int     m_cmb [2][5];
    longint m_x1 [2];
    longint m_y  [2];
    int     m_phase;
    longint exp_l [$];
    longint exp_r [$];

    function automatic longint clamp18(input longint v);
        if (v > 131071)  return 131071;
        if (v < -131072) return -131072;
        return v;
    endfunction

    function automatic void model_reset();
        for (int c = 0; c < 2; c++) begin
            for (int k = 0; k < 5; k++) begin
                m_int[c][k] = 0;
                m_cmb[c][k] = 0;
            end
            m_x1[c] = 0;
            m_y[c]  = 0;
        end
        m_phase = 0;
        exp_l.delete();
        exp_r.delete();
    endfunction

    function automatic void model_step(input bit bl, input bit br);
        longint res [2];
        for (int c = 0; c < 2; c++) begin
            int v;
            v = ((c == 0) ? bl : br) ? 1 : -1;
            for (int k = 0; k < 5; k++) begin
                m_int[c][k] = m_int[c][k] + v;
                v = m_int[c][k];
            end
        end
        if (m_phase == 63) begin
            for (int c = 0; c < 2; c++) begin
                int     v;
                longint s;
                v = m_int[c][4];
                for (int k = 0; k < 5; k++) begin
                    int d;
                    d = v - m_cmb[c][k];
                    m_cmb[c][k] = v;
                    v = d;
                end
                s = clamp18((longint'(v) + 4096) >>> 13);
                m_y[c]  = s - m_x1[c] + m_y[c] - (m_y[c] >>> 10);
                m_x1[c] = s;
                res[c]  = clamp18(m_y[c]);
            end
            exp_l.push_back(res[0]);
            exp_r.push_back(res[1]);
        end
        m_phase = (m_phase + 1) % 64;
    endfunction

    function automatic bit pat(input int mode, input int i);
        case (mode)
            0:       return 1'b0;
            1:       return 1'b1;
            2:       return (i % 2) == 1;
            3:       return (i % 4) != 0;
            4:       return (i % 4) == 0;
            default: return ((i * 37) % 101) < 50;
        endcase
    endfunction

    // ---------------- checking helpers ---------------------------------------
    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_true(input string req, input string what,
                              input bit ok, input longint act);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d outside expected bound", req, what, act);
        end
    endtask

    // ---------------- output monitor -----------------------------------------
    longint last_l = 0;
    longint last_r = 0;
    longint prev_l = 0;
    longint prev_r = 0;
    bit     have_prev = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            have_prev = 1'b0;
        end else begin
            if (out_vld) begin
                if (exp_l.size() == 0) begin
                    check(cur_req, "unexpected out_vld (R9)", 1, 0);
                end else begin
                    longint el;
                    longint er;
                    el = exp_l.pop_front();
                    er = exp_r.pop_front();
                    check(cur_req, "left word", longint'(out_left), el);
                    check(cur_req, "right word (R8)", longint'(out_right), er);
                end
                last_l = longint'(out_left);
                last_r = longint'(out_right);
            end else if (have_prev) begin
                // R10: words hold between pulses
                check("R10", "left hold", longint'(out_left), prev_l);
                check("R10", "right hold", longint'(out_right), prev_r);
            end
            prev_l    = longint'(out_left);
            prev_r    = longint'(out_right);
            have_prev = 1'b1;
        end
    end

    // ---------------- stimulus tasks -----------------------------------------
    task automatic reset_dut();
        @(negedge clk);
        rst    = 1'b1;
        in_vld = 1'b0;
        repeat (3) @(negedge clk);
        model_reset();
        rst = 1'b0;
    endtask

    task automatic strobe(input bit bl, input bit br);
        @(negedge clk);
        in_vld   = 1'b1;
        in_left  = bl;
        in_right = br;
        model_step(bl, br);
    endtask

    task automatic run_frames(input int nfr, input int ml, input int mr, input int gap);
        for (int i = 0; i < nfr * 64; i++) begin
            strobe(pat(ml, i), pat(mr, i));
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                in_vld   = 1'b0;
                in_left  = ~in_left;
                in_right = ~in_right;
            end
        end
        @(negedge clk);
        in_vld = 1'b0;
        repeat (4) @(negedge clk);
        check("R3", "pending words after run", exp_l.size(), 0);
    endtask

    // R1: state after reset
    task automatic t_reset();
        cur_req = "R1";
        reset_dut();
        @(negedge clk);
        check("R1", "out_vld after reset", out_vld, 0);
        check("R1", "out_left after reset", longint'(out_left), 0);
        check("R1", "out_right after reset", longint'(out_right), 0);
    endtask

    // R3 / R9: pulse timing relative to the frame-completing strobe
    task automatic t_latency();
        cur_req = "R3";
        reset_dut();
        for (int i = 0; i < 63; i++) begin
            strobe(1'b1, 1'b0);
        end
        check("R9", "no pulse before 64 strobes", out_vld, 0);
        strobe(1'b1, 1'b0);
        @(negedge clk);
        in_vld = 1'b0;
        check("R3", "out_vld one cycle after last strobe", out_vld, 0);
        @(negedge clk);
        check("R3", "out_vld two cycles after last strobe", out_vld, 1);
        @(negedge clk);
        check("R3", "out_vld width", out_vld, 0);
        repeat (2) @(negedge clk);
        check("R3", "pending words after frame", exp_l.size(), 0);
    endtask

    // R2 / R6: constant streams, clamp at full scale
    task automatic t_constant();
        cur_req = "R6";
        reset_dut();
        run_frames(40, 1, 0, 0);
        check_true("R2", "ones stream gives positive left", last_l > 0, last_l);
        check_true("R2", "zeros stream gives negative right", last_r < 0, last_r);
        check_true("R6", "left near clamped level", last_l > 120000 && last_l <= 131071, last_l);
    endtask

    // R5: half-rate tone is cancelled by the cascade
    task automatic t_alternate();
        cur_req = "R5";
        reset_dut();
        run_frames(40, 2, 2, 0);
        check_true("R5", "alternating stream settles near zero",
                   (last_l >= -16) && (last_l <= 16), last_l);
    endtask

    // R7 / R8: DC removal on two different densities
    task automatic t_stereo_dc();
        cur_req = "R7";
        reset_dut();
        run_frames(256, 3, 4, 0);
        check_true("R7", "left decays below steady input",
                   (last_l > 0) && (last_l < 57000), last_l);
        check_true("R8", "right decays and stays negative",
                   (last_r < 0) && (last_r > -57000), last_r);
    endtask

    // R4: idle cycles with toggling bits do not count
    task automatic t_gaps();
        cur_req = "R4";
        reset_dut();
        run_frames(20, 5, 3, 2);
    endtask

    // R9 / R1: reset inside a frame restarts everything
    task automatic t_midreset();
        cur_req = "R9";
        reset_dut();
        for (int i = 0; i < 30; i++) begin
            strobe(pat(2, i), pat(5, i));
        end
        reset_dut();
        @(negedge clk);
        check("R1", "out_left zero after mid-frame reset", longint'(out_left), 0);
        run_frames(8, 0, 1, 0);
    endtask

    // ---------------- watchdog -----------------------------------------------
    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    // ---------------- sequence -----------------------------------------------
    initial begin
        model_reset();
        t_reset();
        t_latency();
        t_constant();
        t_alternate();
        t_stereo_dc();
        t_gaps();
        t_midreset();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule